// File: doc/BRIEF.md
# Interrupt Source Bank

This block holds the per-source state for a bank of interrupt sources and decides when each source is offered to a downstream presentation layer. Sources are numbered from a fixed base value. Each source is built as either a message source, which is triggered by a pulse, or a level source, which follows a wire. Each source stores a target server, a priority, a saved priority and a small set of status flags. A priority of 0xFF masks the source.

The presentation layer feeds back three kinds of events. A reject returns a source it could not take. An end-of-interrupt retires a level source. A resend asks the bank to walk every source again. A command port sets the routing and priority of a source, reads them back, mutes a source or unmutes it, and answers every command one cycle later with a status code. Presentation requests leave through a single valid/ready channel, one per accepted handshake.

Top module: `intsrc_bank`

## Requirements
- R1: After reset, every source has server 0, priority 0xFF and saved priority 0xFF, all flags are clear, and no presentation request or command response is valid.
- R2: A command (op code 0 = route, 1 = query, 2 = mute, 3 = unmute) gets a response in the cycle after it is accepted. The code is 8'hFD if the number is below BASE or at or above BASE+NUM_SRC. A route command also gets 8'hFD if its server is NUM_SRV or more, or if its 9-bit priority is above 0xFF. Otherwise the code is 0. A rejected command changes no state.
- R3: A message trigger on an unmasked source puts up a request with that source's number, server and priority in the next cycle. The same trigger on a masked source only marks the source masked-pending.
- R4: A level source's asserted flag follows its input on both edges. On an edge, the source is delivered if it is unmasked, asserted and not yet sent, and delivery sets its sent flag. A level source that is already sent is not delivered again.
- R5: A reject for a source sets its rejected flag and clears its sent flag.
- R6: A resend starts a walk from the lowest source upward, one source per cycle, and the walk holds while a request is waiting on ready. For a rejected message source, the walk clears the rejected flag and presents the source once if it is unmasked. For a level source, the walk applies the level rule of R4.
- R7: An end-of-interrupt clears the sent flag of a level source, so a later resend can deliver that source again.
- R8: A route write updates the server, priority and saved priority. After the write, an unmasked message source that was masked-pending is presented and its flag is cleared, and a level source is checked against the R4 rule.
- R9: Mute sets the priority to 0xFF and copies the old priority to the saved priority. Unmute copies the saved priority back into the priority. Muting a source whose request is still waiting withdraws that request: a message source becomes masked-pending and a level source loses its sent flag.
- R10: When several sources request at once, the lowest-numbered one is offered first. An offered request keeps the same source number while ready is low, and exactly one request is retired per cycle in which valid and ready are both high.
- R11: A query returns the stored server and priority of the addressed source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_line_i | input | NUM_SRC | Per-source trigger: a pulse for message sources, a level for level sources |
| reject_vld_i | input | 1 | Reject strobe |
| reject_num_i | input | NUM_W | Number of the rejected source |
| eoi_vld_i | input | 1 | End-of-interrupt strobe |
| eoi_num_i | input | NUM_W | Number of the source being retired |
| resend_i | input | 1 | Starts a resend walk |
| cmd_vld_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | Command op code |
| cmd_num_i | input | NUM_W | Source number addressed by the command |
| cmd_srv_i | input | SRV_IN_W | Server for a route command |
| cmd_prio_i | input | 9 | Priority for a route command |
| rsp_vld_o | output | 1 | Response valid |
| rsp_code_o | output | 8 | Status: 0 on success, 8'hFD on error |
| rsp_srv_o | output | SRV_W | Server returned by a query |
| rsp_prio_o | output | 8 | Priority returned by a query |
| pres_vld_o | output | 1 | Presentation request valid |
| pres_rdy_i | input | 1 | Presentation layer ready |
| pres_num_o | output | NUM_W | Source number offered |
| pres_srv_o | output | SRV_W | Target server of the offered source |
| pres_prio_o | output | 8 | Priority of the offered source |

## Verification
The bench builds the bank with eight sources at base 32 and four servers. Sources 0 to 3 are message sources and sources 4 to 7 are level sources, so both delivery rules are tested in one instance. Because the base is not zero, numbers just below and just above the window are tested. The server limit of four lets route commands aim one server past the end. An eight-entry walk is short enough to watch the resend order and the stall against ready within a few cycles. Random commands with numbers, servers and priorities that straddle every limit are checked against a bench model of each source's routing fields.

// File: rtl/intsrc_pkg.sv
package intsrc_pkg;

    localparam logic [7:0] PRIO_MASKED = 8'hFF;
    localparam logic [7:0] RSP_OK      = 8'h00;
    localparam logic [7:0] RSP_BAD     = 8'hFD;

    typedef enum logic [1:0] {
        OP_ROUTE   = 2'd0,
        OP_QUERY   = 2'd1,
        OP_MUTE    = 2'd2,
        OP_UNMUTE  = 2'd3
    } cfg_op_e;

    typedef struct packed {
        logic [7:0] prio;
        logic [7:0] saved;
        logic       asserted;
        logic       sent;
        logic       rejected;
        logic       mpend;
        logic       req;
    } slot_t;

    // level delivery rule: unmasked, asserted and not yet sent
    function automatic slot_t level_try(slot_t s);
        slot_t r;
        r = s;
        if ((s.prio != PRIO_MASKED) && s.asserted && !s.sent) begin
            r.sent = 1'b1;
            r.req  = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/intsrc_slot.sv
module intsrc_slot
    import intsrc_pkg::*;
#(
    parameter int   SRV_W    = 2,
    parameter logic IS_LEVEL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_i,
    input  logic             grant_i,
    input  logic             reject_i,
    input  logic             eoi_i,
    input  logic             wr_i,
    input  logic [SRV_W-1:0] wr_srv_i,
    input  logic [7:0]       wr_prio_i,
    input  logic [7:0]       wr_saved_i,
    input  logic             scan_i,
    output slot_t            st_o,
    output logic [SRV_W-1:0] srv_o
);

    slot_t            st_d, st_q;
    logic [SRV_W-1:0] srv_d, srv_q;

    always_comb begin
        st_d  = st_q;
        srv_d = srv_q;

        if (grant_i) st_d.req = 1'b0;

        if (reject_i) begin
            st_d.rejected = 1'b1;
            st_d.sent     = 1'b0;
        end

        if (eoi_i && IS_LEVEL) st_d.sent = 1'b0;

        if (IS_LEVEL) begin
            st_d.asserted = line_i;
            if (line_i != st_q.asserted) st_d = level_try(st_d);
        end else if (line_i) begin
            if (st_d.prio == PRIO_MASKED) st_d.mpend = 1'b1;
            else                          st_d.req   = 1'b1;
        end

        if (wr_i) begin
            srv_d      = wr_srv_i;
            st_d.prio  = wr_prio_i;
            st_d.saved = wr_saved_i;
            if (wr_prio_i == PRIO_MASKED) begin
                if (st_d.req) begin
                    st_d.req = 1'b0;
                    if (IS_LEVEL) st_d.sent  = 1'b0;
                    else          st_d.mpend = 1'b1;
                end
            end else if (IS_LEVEL) begin
                st_d = level_try(st_d);
            end else if (st_d.mpend) begin
                st_d.mpend = 1'b0;
                st_d.req   = 1'b1;
            end
        end

        if (scan_i) begin
            if (IS_LEVEL) begin
                st_d = level_try(st_d);
            end else if (st_d.rejected) begin
                st_d.rejected = 1'b0;
                if (st_d.prio != PRIO_MASKED) st_d.req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= '{prio: PRIO_MASKED, saved: PRIO_MASKED, default: '0};
            srv_q <= '0;
        end else begin
            st_q  <= st_d;
            srv_q <= srv_d;
        end
    end

    assign st_o  = st_q;
    assign srv_o = srv_q;

    // R3
    masked_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req |-> (st_q.prio != PRIO_MASKED));

    // R7
    msg_never_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(IS_LEVEL == 1'b0 && st_q.sent));

    // R4
    lvl_req_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_LEVEL && $rose(st_q.req)) |-> (st_q.sent && st_q.asserted));

endmodule

// File: rtl/intsrc_arb.sv
module intsrc_arb #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_i,
    input  logic             rdy_i,
    output logic             vld_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [N-1:0]     grant_o
);

    typedef struct packed {
        logic             hold;
        logic [IDX_W-1:0] idx;
    } lock_t;

    lock_t            lk_d, lk_q;
    logic [IDX_W-1:0] pick;
    logic             any;

    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) pick = IDX_W'(i);
        end
        any = |req_i;
    end

    always_comb begin
        if (lk_q.hold) begin
            vld_o = req_i[lk_q.idx];
            idx_o = lk_q.idx;
        end else begin
            vld_o = any;
            idx_o = pick;
        end
        grant_o = '0;
        if (vld_o && rdy_i) grant_o[idx_o] = 1'b1;
        lk_d.hold = vld_o && !rdy_i;
        lk_d.idx  = idx_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

    // R10
    pres_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && !rdy_i) |=> (!vld_o || $stable(idx_o)));

    // R10
    grant_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~req_i) == '0);

endmodule

// File: rtl/intsrc_cfg.sv
module intsrc_cfg
    import intsrc_pkg::*;
#(
    parameter int N        = 16,
    parameter int NUM_W    = 12,
    parameter int BASE     = 16,
    parameter int NUM_SRV  = 4,
    parameter int SRV_IN_W = 8,
    parameter int SRV_W    = 2,
    parameter int IDX_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_vld_i,
    input  logic [1:0]          cmd_op_i,
    input  logic [NUM_W-1:0]    cmd_num_i,
    input  logic [SRV_IN_W-1:0] cmd_srv_i,
    input  logic [8:0]          cmd_prio_i,
    input  logic [SRV_W-1:0]    cur_srv_i,
    input  logic [7:0]          cur_prio_i,
    input  logic [7:0]          cur_saved_i,
    output logic [IDX_W-1:0]    idx_o,
    output logic                wr_o,
    output logic [SRV_W-1:0]    wr_srv_o,
    output logic [7:0]          wr_prio_o,
    output logic [7:0]          wr_saved_o,
    output logic                rsp_vld_o,
    output logic [7:0]          rsp_code_o,
    output logic [SRV_W-1:0]    rsp_srv_o,
    output logic [7:0]          rsp_prio_o
);

    localparam logic [SRV_IN_W:0] SRV_LIM = (SRV_IN_W + 1)'(NUM_SRV);

    typedef struct packed {
        logic             vld;
        logic [7:0]       code;
        logic [SRV_W-1:0] srv;
        logic [7:0]       prio;
    } rsp_t;

    rsp_t    rsp_d, rsp_q;
    cfg_op_e op;
    logic    hit, ok;

    always_comb begin
        op  = cfg_op_e'(cmd_op_i);
        hit = 1'b0;
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (cmd_num_i == NUM_W'(BASE + i)) begin
                hit   = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
        ok = hit;
        if (op == OP_ROUTE) begin
            ok = hit && ({1'b0, cmd_srv_i} < SRV_LIM) && !cmd_prio_i[8];
        end

        wr_o       = 1'b0;
        wr_srv_o   = cur_srv_i;
        wr_prio_o  = cur_prio_i;
        wr_saved_o = cur_saved_i;
        unique case (op)
            OP_ROUTE: begin
                wr_o       = cmd_vld_i && ok;
                wr_srv_o   = SRV_W'(cmd_srv_i);
                wr_prio_o  = cmd_prio_i[7:0];
                wr_saved_o = cmd_prio_i[7:0];
            end
            OP_MUTE: begin
                wr_o       = cmd_vld_i && ok;
                wr_prio_o  = PRIO_MASKED;
                wr_saved_o = cur_prio_i;
            end
            OP_UNMUTE: begin
                wr_o       = cmd_vld_i && ok;
                wr_prio_o  = cur_saved_i;
                wr_saved_o = cur_saved_i;
            end
            default: wr_o = 1'b0;
        endcase

        rsp_d.vld  = cmd_vld_i;
        rsp_d.code = ok ? RSP_OK : RSP_BAD;
        rsp_d.srv  = (ok && op == OP_QUERY) ? cur_srv_i  : '0;
        rsp_d.prio = (ok && op == OP_QUERY) ? cur_prio_i : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_vld_o  = rsp_q.vld;
    assign rsp_code_o = rsp_q.code;
    assign rsp_srv_o  = rsp_q.srv;
    assign rsp_prio_o = rsp_q.prio;

    // R2
    rsp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld_o |-> (rsp_code_o == RSP_OK || rsp_code_o == RSP_BAD));

    // R2
    wr_means_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |=> (rsp_vld_o && rsp_code_o == RSP_OK));

endmodule

// File: rtl/intsrc_bank.sv
module intsrc_bank
    import intsrc_pkg::*;
#(
    parameter int                 NUM_SRC    = 16,
    parameter int                 NUM_W      = 12,
    parameter int                 BASE       = 16,
    parameter int                 NUM_SRV    = 4,
    parameter int                 SRV_IN_W   = 8,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0,
    localparam int                IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int                SRV_W      = (NUM_SRV > 1) ? $clog2(NUM_SRV) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_line_i,
    input  logic                reject_vld_i,
    input  logic [NUM_W-1:0]    reject_num_i,
    input  logic                eoi_vld_i,
    input  logic [NUM_W-1:0]    eoi_num_i,
    input  logic                resend_i,
    input  logic                cmd_vld_i,
    input  logic [1:0]          cmd_op_i,
    input  logic [NUM_W-1:0]    cmd_num_i,
    input  logic [SRV_IN_W-1:0] cmd_srv_i,
    input  logic [8:0]          cmd_prio_i,
    output logic                rsp_vld_o,
    output logic [7:0]          rsp_code_o,
    output logic [SRV_W-1:0]    rsp_srv_o,
    output logic [7:0]          rsp_prio_o,
    output logic                pres_vld_o,
    input  logic                pres_rdy_i,
    output logic [NUM_W-1:0]    pres_num_o,
    output logic [SRV_W-1:0]    pres_srv_o,
    output logic [7:0]          pres_prio_o
);

    typedef struct packed {
        logic             act;
        logic [IDX_W-1:0] idx;
    } walk_t;

    walk_t            walk_d, walk_q;
    slot_t            st   [NUM_SRC];
    logic [SRV_W-1:0] srv  [NUM_SRC];
    logic [NUM_SRC-1:0] req_vec, grant_vec, scan_hit, wr_hit;
    logic [NUM_SRC-1:0] rej_hit, eoi_hit;
    logic [IDX_W-1:0] arb_idx, cfg_idx;
    logic             stall;
    logic             cfg_wr;
    logic [SRV_W-1:0] wr_srv;
    logic [7:0]       wr_prio, wr_saved;

    // resend walk: one source per cycle, held while an offer waits
    always_comb begin
        stall    = pres_vld_o && !pres_rdy_i;
        walk_d   = walk_q;
        scan_hit = '0;
        if (resend_i) begin
            walk_d.act = 1'b1;
            walk_d.idx = '0;
        end else if (walk_q.act && !stall) begin
            scan_hit[walk_q.idx] = 1'b1;
            if (walk_q.idx == IDX_W'(NUM_SRC - 1)) walk_d.act = 1'b0;
            else                                    walk_d.idx = walk_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) walk_q <= '0;
        else        walk_q <= walk_d;
    end

    always_comb begin
        wr_hit = '0;
        if (cfg_wr) wr_hit[cfg_idx] = 1'b1;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
        assign rej_hit[g] = reject_vld_i && (reject_num_i == NUM_W'(BASE + g));
        assign eoi_hit[g] = eoi_vld_i    && (eoi_num_i    == NUM_W'(BASE + g));
        assign req_vec[g] = st[g].req;

        intsrc_slot #(
            .SRV_W    (SRV_W),
            .IS_LEVEL (LEVEL_MASK[g])
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .line_i     (src_line_i[g]),
            .grant_i    (grant_vec[g]),
            .reject_i   (rej_hit[g]),
            .eoi_i      (eoi_hit[g]),
            .wr_i       (wr_hit[g]),
            .wr_srv_i   (wr_srv),
            .wr_prio_i  (wr_prio),
            .wr_saved_i (wr_saved),
            .scan_i     (scan_hit[g]),
            .st_o       (st[g]),
            .srv_o      (srv[g])
        );
    end

    intsrc_arb #(
        .N     (NUM_SRC),
        .IDX_W (IDX_W)
    ) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_vec),
        .rdy_i   (pres_rdy_i),
        .vld_o   (pres_vld_o),
        .idx_o   (arb_idx),
        .grant_o (grant_vec)
    );

    intsrc_cfg #(
        .N        (NUM_SRC),
        .NUM_W    (NUM_W),
        .BASE     (BASE),
        .NUM_SRV  (NUM_SRV),
        .SRV_IN_W (SRV_IN_W),
        .SRV_W    (SRV_W),
        .IDX_W    (IDX_W)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_vld_i   (cmd_vld_i),
        .cmd_op_i    (cmd_op_i),
        .cmd_num_i   (cmd_num_i),
        .cmd_srv_i   (cmd_srv_i),
        .cmd_prio_i  (cmd_prio_i),
        .cur_srv_i   (srv[cfg_idx]),
        .cur_prio_i  (st[cfg_idx].prio),
        .cur_saved_i (st[cfg_idx].saved),
        .idx_o       (cfg_idx),
        .wr_o        (cfg_wr),
        .wr_srv_o    (wr_srv),
        .wr_prio_o   (wr_prio),
        .wr_saved_o  (wr_saved),
        .rsp_vld_o   (rsp_vld_o),
        .rsp_code_o  (rsp_code_o),
        .rsp_srv_o   (rsp_srv_o),
        .rsp_prio_o  (rsp_prio_o)
    );

    assign pres_num_o  = NUM_W'(BASE) + NUM_W'(arb_idx);
    assign pres_srv_o  = srv[arb_idx];
    assign pres_prio_o = st[arb_idx].prio;

    // R6
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_q.act && stall && !resend_i) |=> $stable(walk_q.idx));

    // R6
    walk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resend_i |=> (walk_q.act && walk_q.idx == '0));

    // R3
    offer_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pres_vld_o |-> (pres_prio_o != PRIO_MASKED));

endmodule

// File: tb/sim_intsrc_bank.sv
module sim_intsrc_bank;

    localparam int N    = 8;
    localparam int NW   = 12;
    localparam int BASE = 32;
    localparam int NSRV = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   line = '0;
    logic           rej_v = 0, eoi_v = 0, resend = 0, cmd_v = 0, rdy = 0;
    logic [NW-1:0]  rej_n = '0, eoi_n = '0, cmd_n = '0;
    logic [1:0]     cmd_op = '0;
    logic [7:0]     cmd_srv = '0;
    logic [8:0]     cmd_prio = '0;
    logic           rsp_v, pres_v;
    logic [7:0]     rsp_code, rsp_prio, pres_prio;
    logic [1:0]     rsp_srv, pres_srv;
    logic [NW-1:0]  pres_num;

    int checks = 0, fails = 0;
    bit done = 0;
    int m_srv [N];
    int m_prio[N];
    int m_sav [N];

    always #2.5 clk = ~clk;

    intsrc_bank #(
        .NUM_SRC(N), .NUM_W(NW), .BASE(BASE), .NUM_SRV(NSRV),
        .SRV_IN_W(8), .LEVEL_MASK(8'hF0)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .src_line_i(line),
        .reject_vld_i(rej_v), .reject_num_i(rej_n),
        .eoi_vld_i(eoi_v), .eoi_num_i(eoi_n), .resend_i(resend),
        .cmd_vld_i(cmd_v), .cmd_op_i(cmd_op), .cmd_num_i(cmd_n),
        .cmd_srv_i(cmd_srv), .cmd_prio_i(cmd_prio),
        .rsp_vld_o(rsp_v), .rsp_code_o(rsp_code), .rsp_srv_o(rsp_srv),
        .rsp_prio_o(rsp_prio), .pres_vld_o(pres_v), .pres_rdy_i(rdy),
        .pres_num_o(pres_num), .pres_srv_o(pres_srv), .pres_prio_o(pres_prio)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    function automatic int exp_code(int op, int num, int srv, int prio);
        if (num < BASE || num >= BASE + N) return 8'hFD;
        if (op == 0 && (srv >= NSRV || prio > 255)) return 8'hFD;
        return 0;
    endfunction

    // issue one command, check code (R2) and query data (R11), update model
    task automatic cmd(input int op, input int num, input int srv, input int prio);
        int code, i;
        code = exp_code(op, num, srv, prio);
        cmd_v = 1; cmd_op = op[1:0]; cmd_n = num[NW-1:0];
        cmd_srv = srv[7:0]; cmd_prio = prio[8:0];
        step();
        cmd_v = 0;
        chk(rsp_v == 1'b1, "R2 response valid", int'(rsp_v), 1);
        chk(int'(rsp_code) == code, "R2 status code", int'(rsp_code), code);
        if (code == 0) begin
            i = num - BASE;
            if (op == 1) begin
                chk(int'(rsp_srv) == m_srv[i], "R11 query server", int'(rsp_srv), m_srv[i]);
                chk(int'(rsp_prio) == m_prio[i], "R11 query priority", int'(rsp_prio), m_prio[i]);
            end else if (op == 0) begin
                m_srv[i] = srv; m_prio[i] = prio; m_sav[i] = prio;
            end else if (op == 2) begin
                m_sav[i] = m_prio[i]; m_prio[i] = 255;
            end else begin
                m_prio[i] = m_sav[i];
            end
        end
    endtask

    task automatic expect_offer(input string tag, input int num, input int srv, input int prio);
        chk(pres_v == 1'b1, {tag, " offer valid"}, int'(pres_v), 1);
        chk(int'(pres_num) == num, {tag, " offer number"}, int'(pres_num), num);
        chk(int'(pres_srv) == srv, {tag, " offer server"}, int'(pres_srv), srv);
        chk(int'(pres_prio) == prio, {tag, " offer priority"}, int'(pres_prio), prio);
    endtask

    task automatic expect_none(input string tag);
        chk(pres_v == 1'b0, {tag, " no offer"}, int'(pres_v), 0);
    endtask

    task automatic take(); rdy = 1; step(); rdy = 0; endtask
    task automatic pulse_line(input int i); line[i] = 1; step(); line[i] = 0; endtask
    task automatic do_reject(input int num); rej_v = 1; rej_n = num[NW-1:0]; step(); rej_v = 0; endtask
    task automatic do_eoi(input int num); eoi_v = 1; eoi_n = num[NW-1:0]; step(); eoi_v = 0; endtask
    task automatic do_resend(); resend = 1; step(); resend = 0; endtask

    task automatic wait_offer(input string tag, input int num);
        int seen;
        seen = 0;
        for (int k = 0; k < 2 * N + 2; k++) begin
            if (pres_v && seen == 0) seen = 1;
            if (seen == 0) step();
        end
        chk(seen == 1, {tag, " walk offers"}, seen, 1);
        chk(int'(pres_num) == num, {tag, " walk number"}, int'(pres_num), num);
    endtask

    task automatic idle(input int n); for (int k = 0; k < n; k++) step(); endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_srv[i] = 0; m_prio[i] = 255; m_sav[i] = 255;
        end
        void'($urandom(32'd20240611));
        idle(3);
        rst_n = 1;
        step();
        // R1 reset state
        chk(pres_v == 0, "R1 no offer after reset", int'(pres_v), 0);
        chk(rsp_v == 0, "R1 no response after reset", int'(rsp_v), 0);
        cmd(1, BASE + 0, 0, 0);
        cmd(1, BASE + 7, 0, 0);

        // R3 message on unmasked source
        cmd(0, 32, 2, 5);
        pulse_line(0);
        expect_offer("R3", 32, 2, 5);
        take();
        expect_none("R10 after handshake");

        // R3 masked message, R8 release on route write
        pulse_line(1);
        expect_none("R3 masked");
        cmd(0, 33, 1, 7);
        expect_offer("R8 masked-pending release", 33, 1, 7);
        take();

        // R5/R6 reject then resend for message source
        do_reject(33);
        expect_none("R5 after reject");
        do_resend();
        wait_offer("R6 rejected message", 33);
        take();
        do_resend();
        idle(N + 3);
        expect_none("R6 second resend");

        // R4/R7 level source
        cmd(0, 36, 3, 9);
        line[4] = 1; step();
        expect_offer("R4 level edge", 36, 3, 9);
        take();
        do_resend();
        idle(N + 3);
        expect_none("R4 sent blocks redelivery");
        do_eoi(36);
        expect_none("R7 eoi alone");
        do_resend();
        wait_offer("R7 eoi then resend", 36);
        take();
        do_reject(36);
        do_resend();
        wait_offer("R5 reject clears sent", 36);
        take();
        line[4] = 0; step();
        do_eoi(36);
        do_resend();
        idle(N + 3);
        expect_none("R4 deasserted level");

        // R9 mute / unmute
        cmd(0, 34, 0, 12);
        cmd(2, 34, 0, 0);
        cmd(1, 34, 0, 0);
        pulse_line(2);
        expect_none("R9 muted source");
        cmd(3, 34, 0, 0);
        expect_offer("R9 unmute releases", 34, 0, 12);
        take();
        cmd(1, 34, 0, 0);
        pulse_line(2);
        expect_offer("R9 waiting offer", 34, 0, 12);
        cmd(2, 34, 0, 0);
        expect_none("R9 mute withdraws");
        cmd(3, 34, 0, 0);
        expect_offer("R9 offer restored", 34, 0, 12);
        take();

        // R10 ordering and hold
        cmd(0, 35, 1, 3);
        line[0] = 1; line[3] = 1; step(); line[0] = 0; line[3] = 0;
        expect_offer("R10 lowest first", 32, 2, 5);
        idle(2);
        expect_offer("R10 held while not ready", 32, 2, 5);
        take();
        expect_offer("R10 next source", 35, 1, 3);
        take();
        expect_none("R10 drained");

        // R2 invalid commands
        cmd(1, 31, 0, 0);
        cmd(1, 40, 0, 0);
        cmd(0, 32, 4, 1);
        cmd(0, 32, 1, 256);
        cmd(1, 32, 0, 0);

        // random command mix against model
        rdy = 1;
        for (int k = 0; k < 300; k++) begin
            int op, num, srv, prio;
            op   = $urandom_range(3, 0);
            num  = $urandom_range(BASE + N + 1, BASE - 2);
            srv  = $urandom_range(NSRV + 1, 0);
            prio = ($urandom_range(3, 0) == 0) ? $urandom_range(300, 250) : $urandom_range(255, 0);
            cmd(op, num, srv, prio);
        end
        for (int i = 0; i < N; i++) cmd(1, BASE + i, 0, 0);
        rdy = 0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule